// File: doc/BRIEF.md
# Byte/Pair Working Register File

This block is the working-register store of a small 8-bit CPU core. Six byte-wide general registers can be read and written one byte at a time through two combinational read ports and one write port, each addressed by a 3-bit register code. The same storage can also be addressed as three 16-bit pairs. The first register of each pair is the upper byte. A 16-bit stack pointer joins the three pairs on a pair read port, a pair write port and a pair step unit. The step unit counts a selected pair up or down by one.

The pair built from the fifth and sixth registers is driven out all the time as the indirect memory address. Register code 110 does not select storage. Instead it raises a memory-access flag, so the datapath can fetch or store the byte at that address. A separate 16-bit program counter increments or loads in parallel. An asynchronous active-low reset clears the program counter and leaves every other register untouched. The reset is released in step with the clock.

Top module: `wreg_pair_file`

## Requirements
- R1: Register codes 000..101 select the six byte registers (call them r0..r5). A write through the write port appears on the read ports after the next rising clock edge. Both read ports are combinational.
- R2: Pair code 00 covers r0:r1, 01 covers r2:r3, 10 covers r4:r5 and 11 is the stack pointer. In every byte pair the lower-numbered register is bits 15:8. A pair write loads both bytes at the next edge.
- R3: `hl_ptr` always equals {r4, r5}, with r4 in bits 15:8.
- R4: Code 110 on a read port sets that port's memory flag (`mem_rd_a`, `mem_rd_b`). Code 110 with `wr_en` sets `mem_wr`. Codes 110 and 111 read 00h and changing no register when written; code 111 raises no flag.
- R5: A pair step adds 1 (`pair_step_dn`=0) or subtracts 1 (`pair_step_dn`=1) on the selected pair. The result wraps modulo 2^16 and the step works on the stack pointer too.
- R6: When writes meet on the same byte in one cycle, the pair write wins over the step, and the step wins over the byte write.
- R7: `pc_load` puts `pc_load_val` into the program counter at the next edge and takes priority over `pc_inc`. `pc_inc` alone adds 1, wrapping FFFFh to 0000h.
- R8: A low `rst_n` forces the program counter to 0000h at once and holds it there until two rising edges after release. The byte registers and the stack pointer keep their contents across reset.
- R9: `sp_out` and the pair read port (code 11) both show the stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_sel | input | 3 | Register code for read port A |
| rd_a_data | output | 8 | Read port A data |
| mem_rd_a | output | 1 | Port A selects the memory operand |
| rd_b_sel | input | 3 | Register code for read port B |
| rd_b_data | output | 8 | Read port B data |
| mem_rd_b | output | 1 | Port B selects the memory operand |
| wr_en | input | 1 | Byte write enable |
| wr_sel | input | 3 | Register code for the byte write |
| wr_data | input | 8 | Byte write data |
| mem_wr | output | 1 | Byte write targets the memory operand |
| pair_rd_sel | input | 2 | Pair code for the pair read port |
| pair_rd_data | output | 16 | Pair read data |
| pair_wr_en | input | 1 | Pair write enable |
| pair_wr_sel | input | 2 | Pair code for the pair write |
| pair_wr_data | input | 16 | Pair write data |
| pair_step_en | input | 1 | Pair step enable |
| pair_step_sel | input | 2 | Pair code for the step |
| pair_step_dn | input | 1 | 1 = decrement, 0 = increment |
| hl_ptr | output | 16 | Memory operand address {r4, r5} |
| sp_out | output | 16 | Stack pointer |
| pc_inc | input | 1 | Program counter increment |
| pc_load | input | 1 | Program counter parallel load |
| pc_load_val | input | 16 | Program counter load value |
| pc_out | output | 16 | Program counter |

## Verification
Read data, memory flags, `hl_ptr`, `sp_out` and `pc_out` follow the stored state combinationally. The bench checks them 1 ns after it drives the inputs at the falling edge. Byte writes, pair writes, steps and program counter updates show up after the next rising edge. The bench updates its reference model at that edge and compares it on the following falling-edge sample. Reset pulls the program counter to zero without waiting for the clock, so it is checked 1 ns after `rst_n` falls. The counter must then stay at zero through the two-edge release.

// File: rtl/wreg_pkg.sv
package wreg_pkg;
  typedef enum logic [2:0] {
    SEL_R0 = 3'd0, SEL_R1 = 3'd1, SEL_R2 = 3'd2, SEL_R3 = 3'd3,
    SEL_R4 = 3'd4, SEL_R5 = 3'd5, SEL_MEM = 3'd6, SEL_ACC = 3'd7
  } byte_sel_e;

  typedef enum logic [1:0] {
    PR_01 = 2'd0, PR_23 = 2'd1, PR_45 = 2'd2, PR_SP = 2'd3
  } pair_sel_e;

  localparam int unsigned NUM_GPR   = 6;
  localparam int unsigned NUM_BPAIR = NUM_GPR / 2;
endpackage

// File: rtl/wreg_step.sv
module wreg_step #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] val,
  input  logic         dn,
  output logic [W-1:0] res
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    if (dn) res = val - ONE;
    else    res = val + ONE;
  end
endmodule

// File: rtl/wreg_pc.sv
module wreg_pc #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] pc
);
  logic [AW-1:0] pc_q, pc_d, pc_plus;
  logic          pc_ce;

  wreg_step #(.W(AW)) i_pc_step (.val(pc_q), .dn(1'b0), .res(pc_plus));

  always_comb begin
    pc_ce = load | inc;
    pc_d  = pc_q;
    if (load)     pc_d = load_val;
    else if (inc) pc_d = pc_plus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_ce) pc_q <= pc_d;
  end

  assign pc = pc_q;

  // R7: load has priority over increment
  a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pc_q == $past(load_val));

  // R7: increment alone adds one with wrap
  a_r7_inc_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> pc_q == $past(pc_q) + AW'(1));

  // R7: no request holds the counter
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load) |=> $stable(pc_q));
endmodule

// File: rtl/wreg_bank.sv
module wreg_bank
  import wreg_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      rd_a_sel,
  output logic [DW-1:0]   rd_a_data,
  input  logic [2:0]      rd_b_sel,
  output logic [DW-1:0]   rd_b_data,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [DW-1:0]   wr_data,
  input  logic [1:0]      pair_rd_sel,
  output logic [2*DW-1:0] pair_rd_data,
  input  logic            pair_wr_en,
  input  logic [1:0]      pair_wr_sel,
  input  logic [2*DW-1:0] pair_wr_data,
  input  logic            step_en,
  input  logic [1:0]      step_sel,
  input  logic            step_dn,
  output logic [2*DW-1:0] hl_ptr,
  output logic [2*DW-1:0] sp_out
);
  localparam int unsigned PW = 2 * DW;

  logic [NUM_GPR-1:0][DW-1:0] gpr_q, gpr_d;
  logic [NUM_GPR-1:0]         gpr_we;
  logic [PW-1:0]              sp_q, sp_d;
  logic                       sp_we;
  logic [PW-1:0]              step_src, step_res;

  function automatic logic [PW-1:0] pair_of(
    input logic [NUM_GPR-1:0][DW-1:0] regs,
    input logic [PW-1:0]              sp,
    input logic [1:0]                 sel
  );
    logic [PW-1:0] v;
    v = sp;
    for (int p = 0; p < NUM_BPAIR; p++)
      if (sel == 2'(p)) v = {regs[2*p], regs[2*p+1]};
    return v;
  endfunction

  function automatic logic [DW-1:0] byte_of(
    input logic [NUM_GPR-1:0][DW-1:0] regs,
    input logic [2:0]                 sel
  );
    logic [DW-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_GPR; i++)
      if (sel == 3'(i)) v = regs[i];
    return v;
  endfunction

  always_comb step_src = pair_of(gpr_q, sp_q, step_sel);

  wreg_step #(.W(PW)) i_pair_step (.val(step_src), .dn(step_dn), .res(step_res));

  // Next state: byte write, then step, then pair write (later wins)
  always_comb begin
    gpr_d  = gpr_q;
    gpr_we = '0;
    sp_d   = sp_q;
    sp_we  = 1'b0;
    for (int i = 0; i < NUM_GPR; i++) begin
      if (wr_en && wr_sel == 3'(i)) begin
        gpr_d[i]  = wr_data;
        gpr_we[i] = 1'b1;
      end
    end
    for (int p = 0; p < NUM_BPAIR; p++) begin
      if (step_en && step_sel == 2'(p)) begin
        {gpr_d[2*p], gpr_d[2*p+1]}   = step_res;
        {gpr_we[2*p], gpr_we[2*p+1]} = 2'b11;
      end
      if (pair_wr_en && pair_wr_sel == 2'(p)) begin
        {gpr_d[2*p], gpr_d[2*p+1]}   = pair_wr_data;
        {gpr_we[2*p], gpr_we[2*p+1]} = 2'b11;
      end
    end
    if (step_en && step_sel == PR_SP) begin
      sp_d  = step_res;
      sp_we = 1'b1;
    end
    if (pair_wr_en && pair_wr_sel == PR_SP) begin
      sp_d  = pair_wr_data;
      sp_we = 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (gpr_we[g]) gpr_q[g] <= gpr_d[g];
    end
  end

  always_ff @(posedge clk) begin
    if (sp_we) sp_q <= sp_d;
  end

  always_comb begin
    rd_a_data    = byte_of(gpr_q, rd_a_sel);
    rd_b_data    = byte_of(gpr_q, rd_b_sel);
    pair_rd_data = pair_of(gpr_q, sp_q, pair_rd_sel);
  end

  assign hl_ptr = {gpr_q[SEL_R4], gpr_q[SEL_R5]};
  assign sp_out = sp_q;

  // R2: a pair write on pair 10 lands high byte in r4, low in r5
  a_r2_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_wr_en && pair_wr_sel == PR_45) |=>
      (gpr_q[4] == $past(pair_wr_data[PW-1:DW]) && gpr_q[5] == $past(pair_wr_data[DW-1:0])));

  // R4: codes 110/111 leave all storage alone
  a_r4_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel[2:1] == 2'b11 && !pair_wr_en && !step_en) |=>
      ($stable(gpr_q) && $stable(sp_q)));

  // R5: stack pointer increment wraps to zero
  a_r5_sp_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_sel == PR_SP && !step_dn && !pair_wr_en && sp_q == '1) |=> sp_q == '0);

  // R6: pair write beats a byte write on the same register
  a_r6_pair_beats_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_wr_en && pair_wr_sel == PR_01 && wr_en && wr_sel == SEL_R0) |=>
      gpr_q[0] == $past(pair_wr_data[PW-1:DW]));
endmodule

// File: rtl/wreg_pair_file.sv
module wreg_pair_file
  import wreg_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      rd_a_sel,
  output logic [DW-1:0]   rd_a_data,
  output logic            mem_rd_a,
  input  logic [2:0]      rd_b_sel,
  output logic [DW-1:0]   rd_b_data,
  output logic            mem_rd_b,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [DW-1:0]   wr_data,
  output logic            mem_wr,
  input  logic [1:0]      pair_rd_sel,
  output logic [2*DW-1:0] pair_rd_data,
  input  logic            pair_wr_en,
  input  logic [1:0]      pair_wr_sel,
  input  logic [2*DW-1:0] pair_wr_data,
  input  logic            pair_step_en,
  input  logic [1:0]      pair_step_sel,
  input  logic            pair_step_dn,
  output logic [2*DW-1:0] hl_ptr,
  output logic [2*DW-1:0] sp_out,
  input  logic            pc_inc,
  input  logic            pc_load,
  input  logic [2*DW-1:0] pc_load_val,
  output logic [2*DW-1:0] pc_out
);
  localparam int unsigned AW = 2 * DW;

  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  assign mem_rd_a = (rd_a_sel == SEL_MEM);
  assign mem_rd_b = (rd_b_sel == SEL_MEM);
  assign mem_wr   = wr_en && (wr_sel == SEL_MEM);

  wreg_bank #(.DW(DW)) i_bank (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .rd_a_sel     (rd_a_sel),
    .rd_a_data    (rd_a_data),
    .rd_b_sel     (rd_b_sel),
    .rd_b_data    (rd_b_data),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .pair_rd_sel  (pair_rd_sel),
    .pair_rd_data (pair_rd_data),
    .pair_wr_en   (pair_wr_en),
    .pair_wr_sel  (pair_wr_sel),
    .pair_wr_data (pair_wr_data),
    .step_en      (pair_step_en),
    .step_sel     (pair_step_sel),
    .step_dn      (pair_step_dn),
    .hl_ptr       (hl_ptr),
    .sp_out       (sp_out)
  );

  wreg_pc #(.AW(AW)) i_pc (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .inc      (pc_inc),
    .load     (pc_load),
    .load_val (pc_load_val),
    .pc       (pc_out)
  );

  // R8: while the synchronised reset is active the counter reads zero
  a_r8_pc_reset: assert property (@(posedge clk)
    (rst_n_s == 1'b0 && $past(rst_n_s) == 1'b0 && $past(rst_n) == 1'b0) |-> pc_out == '0);

  // R3: memory pointer tracks pair 10 on the pair read port
  a_r3_hl_match: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pair_rd_sel == PR_45) |-> pair_rd_data == hl_ptr);
endmodule

// File: tb/test_wreg_pair_file.sv
module test_wreg_pair_file;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  rd_a_sel, rd_b_sel, wr_sel;
  logic [7:0]  rd_a_data, rd_b_data, wr_data;
  logic        mem_rd_a, mem_rd_b, mem_wr, wr_en;
  logic [1:0]  pair_rd_sel, pair_wr_sel, pair_step_sel;
  logic [15:0] pair_rd_data, pair_wr_data, hl_ptr, sp_out, pc_load_val, pc_out;
  logic        pair_wr_en, pair_step_en, pair_step_dn, pc_inc, pc_load;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [7:0]  m_r [6];
  logic [15:0] m_sp, m_pc;

  always #4 clk = ~clk;

  wreg_pair_file i_wreg_pair_file (
    .clk(clk), .rst_n(rst_n),
    .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data), .mem_rd_a(mem_rd_a),
    .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data), .mem_rd_b(mem_rd_b),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .mem_wr(mem_wr),
    .pair_rd_sel(pair_rd_sel), .pair_rd_data(pair_rd_data),
    .pair_wr_en(pair_wr_en), .pair_wr_sel(pair_wr_sel), .pair_wr_data(pair_wr_data),
    .pair_step_en(pair_step_en), .pair_step_sel(pair_step_sel), .pair_step_dn(pair_step_dn),
    .hl_ptr(hl_ptr), .sp_out(sp_out),
    .pc_inc(pc_inc), .pc_load(pc_load), .pc_load_val(pc_load_val), .pc_out(pc_out)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m_pair(input logic [1:0] s);
    case (s)
      2'd0:    return {m_r[0], m_r[1]};
      2'd1:    return {m_r[2], m_r[3]};
      2'd2:    return {m_r[4], m_r[5]};
      default: return m_sp;
    endcase
  endfunction

  function automatic logic [7:0] m_byte(input logic [2:0] s);
    if (s < 3'd6) return m_r[s];
    return 8'h00;
  endfunction

  task automatic set_idle();
    rd_a_sel = 3'd0; rd_b_sel = 3'd1; wr_en = 1'b0; wr_sel = 3'd0; wr_data = 8'h00;
    pair_rd_sel = 2'd0; pair_wr_en = 1'b0; pair_wr_sel = 2'd0; pair_wr_data = 16'h0;
    pair_step_en = 1'b0; pair_step_sel = 2'd0; pair_step_dn = 1'b0;
    pc_inc = 1'b0; pc_load = 1'b0; pc_load_val = 16'h0;
  endtask

  task automatic check_outputs();
    chk("R1 rd_a", {8'h0, rd_a_data}, {8'h0, m_byte(rd_a_sel)});
    chk("R1 rd_b", {8'h0, rd_b_data}, {8'h0, m_byte(rd_b_sel)});
    chk("R4 mem_rd_a", {15'h0, mem_rd_a}, {15'h0, rd_a_sel == 3'd6});
    chk("R4 mem_rd_b", {15'h0, mem_rd_b}, {15'h0, rd_b_sel == 3'd6});
    chk("R4 mem_wr", {15'h0, mem_wr}, {15'h0, wr_en && wr_sel == 3'd6});
    chk("R2 pair_rd", pair_rd_data, m_pair(pair_rd_sel));
    chk("R3 hl_ptr", hl_ptr, {m_r[4], m_r[5]});
    chk("R9 sp_out", sp_out, m_sp);
    chk("R7 pc_out", pc_out, m_pc);
  endtask

  task automatic model_update();
    logic [15:0] sv;
    logic [15:0] pv;
    pv = m_pair(pair_step_sel);
    sv = pair_step_dn ? pv - 16'd1 : pv + 16'd1;
    if (wr_en && wr_sel < 3'd6) m_r[wr_sel] = wr_data;
    if (pair_step_en) begin
      if (pair_step_sel == 2'd3) m_sp = sv;
      else {m_r[2*pair_step_sel], m_r[2*pair_step_sel+1]} = sv;
    end
    if (pair_wr_en) begin
      if (pair_wr_sel == 2'd3) m_sp = pair_wr_data;
      else {m_r[2*pair_wr_sel], m_r[2*pair_wr_sel+1]} = pair_wr_data;
    end
    if (pc_load)     m_pc = pc_load_val;
    else if (pc_inc) m_pc = m_pc + 16'd1;
  endtask

  task automatic run_cycle();
    #1;
    check_outputs();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic check_all();
    for (int p = 0; p < 4; p++) begin
      set_idle();
      pair_rd_sel = 2'(p);
      rd_a_sel = 3'(2*p); rd_b_sel = 3'(2*p+1);
      run_cycle();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250));
    set_idle();
    m_pc = 16'h0;
    repeat (3) @(negedge clk);
    #1 chk("R8 pc in reset", pc_out, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: fill the byte registers
    for (int i = 0; i < 6; i++) begin
      set_idle();
      wr_en = 1'b1; wr_sel = 3'(i); wr_data = 8'(8'h11 * (i + 1));
      run_cycle();
    end
    set_idle(); pair_wr_en = 1'b1; pair_wr_sel = 2'd3; pair_wr_data = 16'h1234;
    run_cycle();
    check_all();

    // R3: r4=20h, r5=05h gives 2005h
    set_idle(); wr_en = 1'b1; wr_sel = 3'd4; wr_data = 8'h20; run_cycle();
    set_idle(); wr_en = 1'b1; wr_sel = 3'd5; wr_data = 8'h05; run_cycle();
    set_idle(); run_cycle();
    chk("R3 hl_ptr 2005", hl_ptr, 16'h2005);

    // R5: wrap on the stack pointer both ways
    set_idle(); pair_wr_en = 1'b1; pair_wr_sel = 2'd3; pair_wr_data = 16'hFFFF; run_cycle();
    set_idle(); pair_step_en = 1'b1; pair_step_sel = 2'd3; run_cycle();
    set_idle(); run_cycle();
    chk("R5 sp inc wrap", sp_out, 16'h0000);
    set_idle(); pair_step_en = 1'b1; pair_step_sel = 2'd3; pair_step_dn = 1'b1; run_cycle();
    set_idle(); pair_rd_sel = 2'd3; run_cycle();
    chk("R5 sp dec wrap", pair_rd_data, 16'hFFFF);

    // R4: codes 110 and 111 change nothing
    set_idle(); wr_en = 1'b1; wr_sel = 3'd6; wr_data = 8'hA5; rd_a_sel = 3'd6; run_cycle();
    set_idle(); wr_en = 1'b1; wr_sel = 3'd7; wr_data = 8'h5A; rd_b_sel = 3'd7; run_cycle();
    check_all();

    // R6: pair write beats step beats byte write
    set_idle(); pair_wr_en = 1'b1; pair_wr_sel = 2'd0; pair_wr_data = 16'hBEEF;
    pair_step_en = 1'b1; pair_step_sel = 2'd0; wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h77;
    run_cycle();
    set_idle(); pair_rd_sel = 2'd0; run_cycle();
    chk("R6 pair write wins", pair_rd_data, 16'hBEEF);
    set_idle(); pair_wr_en = 1'b1; pair_wr_sel = 2'd1; pair_wr_data = 16'h00FF; run_cycle();
    set_idle(); pair_step_en = 1'b1; pair_step_sel = 2'd1; wr_en = 1'b1; wr_sel = 3'd2; wr_data = 8'h55;
    run_cycle();
    set_idle(); pair_rd_sel = 2'd1; run_cycle();
    chk("R6 step wins over byte", pair_rd_data, 16'h0100);

    // R7: load wins, increment wraps
    set_idle(); pc_load = 1'b1; pc_inc = 1'b1; pc_load_val = 16'hFFFF; run_cycle();
    set_idle(); pc_inc = 1'b1; run_cycle();
    set_idle(); run_cycle();
    chk("R7 pc wrap", pc_out, 16'h0000);

    // R8: reset mid-run clears PC only
    set_idle(); pc_load = 1'b1; pc_load_val = 16'h4321; run_cycle();
    set_idle();
    rst_n = 1'b0;
    #1 chk("R8 pc async clear", pc_out, 16'h0000);
    m_pc = 16'h0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    check_all();

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      set_idle();
      rd_a_sel = 3'($urandom_range(0, 7));
      rd_b_sel = 3'($urandom_range(0, 7));
      wr_en = 1'($urandom_range(0, 1));
      wr_sel = 3'($urandom_range(0, 7));
      wr_data = 8'($urandom);
      pair_rd_sel = 2'($urandom_range(0, 3));
      pair_wr_en = ($urandom_range(0, 3) == 0);
      pair_wr_sel = 2'($urandom_range(0, 3));
      pair_wr_data = 16'($urandom);
      pair_step_en = ($urandom_range(0, 2) == 0);
      pair_step_sel = 2'($urandom_range(0, 3));
      pair_step_dn = 1'($urandom_range(0, 1));
      pc_inc = 1'($urandom_range(0, 1));
      pc_load = ($urandom_range(0, 7) == 0);
      pc_load_val = 16'($urandom);
      run_cycle();
    end
    check_all();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule